// File: doc/BRIEF.md
# Inter-core message send dispatcher

This block turns one 64-bit send command into a single write, sometimes preceded by a read, on the register space of one target core. A command arrives on a valid/ready handshake together with a two-bit kind select and a flag that says whether the command came in as a full 64-bit write. The block decodes the target core, the address and the data. It then drives a simple master port that the per-core register files sit behind. The block does not contain those register files.

There are three command kinds. A vector send raises one interrupt bit on the target by writing a one-hot word to its set register. A mailbox send writes one of eight word-aligned mailbox slots. An arbitrary send writes any 16-bit address on the target. Mailbox and arbitrary sends carry a four-bit keep mask. Each set mask bit preserves one byte of the word already in the target. When the mask is nonzero, the block reads the target word first, merges the bytes, and writes the result back. When the mask is zero, the read is skipped.

Top module: `ipi_send_dispatch`

## Requirements
- R1: The target core driven on `m_core` for both the read and the write equals command bits 25:16.
- R2: A vector send (kind 0) issues no read and writes `1 << word[4:0]` to address 0x1008. Bits 30:27 are ignored for this kind.
- R3: A mailbox send (kind 1) addresses 0x1020 plus (word AND 0x1C).
- R4: An arbitrary send (kind 2) addresses command bits 15:0.
- R5: For kinds 1 and 2, bit 27+i of the command keeps byte i (bits 8i+7:8i) of the word read from the target. The other bytes come from payload bits 63:32.
- R6: A nonzero keep mask causes exactly one read, one cycle long, to the same core and address as the later write. The write is issued only after `m_rvalid` returns the old word.
- R7: A zero keep mask causes no read, and the whole 32-bit payload is written.
- R8: Kinds 1 and 2 with `cmd_is64` low are dropped, and kind 3 is always dropped. A dropped command produces no read and no write, and the block stays ready.
- R9: A command whose core id is at or above `NUM_CORES` is dropped with no bus activity.
- R10: `cmd_ready` is low from the cycle after acceptance until the write cycle has ended. `m_rd` and `m_wr` are never high together, and neither is high while `cmd_ready` is high.
- R11: After reset, `cmd_ready` is high and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_word | input | 64 | Send command word |
| cmd_kind | input | 2 | 0 vector, 1 mailbox, 2 arbitrary, 3 reserved |
| cmd_is64 | input | 1 | Command arrived as a full 64-bit write |
| m_core | output | 10 | Target core id |
| m_addr | output | 16 | Target register address |
| m_rd | output | 1 | Read strobe, one cycle |
| m_wr | output | 1 | Write strobe, one cycle |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data from target |
| m_rvalid | input | 1 | Read data valid |

## Verification
Some properties hold on every cycle and are checked by assertions:
- The two strobes are mutually exclusive, and neither is high while the block is ready.
- A dropped or out-of-range command produces no strobe in the next cycle.
- Core and address hold steady between the read and the write.
- A read strobe is never followed directly by a write strobe.
- Every vector write carries a one-hot word to the set register.

Other behaviour depends on decoded values and on what the target holds, so only the bench scenarios can show it. This covers the byte merge against the old word, the mailbox and arbitrary address arithmetic, and the correct number of reads for each mask. The bench uses a model of target memory that returns read data after a random delay.

// File: rtl/ipi_disp_pkg.sv
package ipi_disp_pkg;
  localparam int CMD_W  = 64;
  localparam int CORE_W = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  localparam logic [ADDR_W-1:0] SET_REG_ADDR = 16'h1008;
  localparam logic [ADDR_W-1:0] MBOX_BASE    = 16'h1020;

  typedef enum logic [1:0] {
    KIND_VEC  = 2'd0,
    KIND_MBOX = 2'd1,
    KIND_ANY  = 2'd2,
    KIND_RSVD = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_WRITE = 2'd3
  } disp_state_e;

  typedef struct packed {
    logic [CORE_W-1:0] core;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  keep;
    logic [DATA_W-1:0] payload;
    logic              is_vec;
  } disp_req_t;

  // One-hot word raising the given interrupt vector
  function automatic logic [DATA_W-1:0] vec_onehot(input logic [4:0] vec);
    return DATA_W'(1) << vec;
  endfunction

  // Word-aligned mailbox slot address
  function automatic logic [ADDR_W-1:0] mbox_addr(input logic [2:0] slot);
    return MBOX_BASE + ADDR_W'({slot, 2'b00});
  endfunction
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_disp_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic [CMD_W-1:0] word,
  input  logic [1:0]       kind,
  input  logic             is64,
  output disp_req_t        req,
  output logic             legal
);
  logic unused_bits;
  assign unused_bits = ^{word[31], word[26]};

  always_comb begin
    req         = '0;
    req.core    = word[25:16];
    req.payload = word[63:32];
    req.keep    = word[30:27];
    legal       = int'(word[25:16]) < NUM_CORES;
    case (cmd_kind_e'(kind))
      KIND_VEC: begin
        req.addr    = SET_REG_ADDR;
        req.payload = vec_onehot(word[4:0]);
        req.keep    = '0;
        req.is_vec  = 1'b1;
      end
      KIND_MBOX: begin
        req.addr = mbox_addr(word[4:2]);
        legal    = legal && is64;
      end
      KIND_ANY: begin
        req.addr = word[15:0];
        legal    = legal && is64;
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipi_byte_merge.sv
module ipi_byte_merge
  import ipi_disp_pkg::*;
(
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_word,
  input  logic [LANES-1:0]  keep,
  output logic [DATA_W-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[8*g +: 8] = keep[g] ? old_word[8*g +: 8] : new_word[8*g +: 8];
  end
endmodule

// File: rtl/ipi_send_dispatch.sv
module ipi_send_dispatch
  import ipi_disp_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [1:0]        cmd_kind,
  input  logic              cmd_is64,
  output logic [CORE_W-1:0] m_core,
  output logic [ADDR_W-1:0] m_addr,
  output logic              m_rd,
  output logic              m_wr,
  output logic [DATA_W-1:0] m_wdata,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_rvalid
);
  disp_state_e       st;
  disp_req_t         dec_req;
  logic              dec_legal;
  logic [LANES-1:0]  r_keep;
  logic [DATA_W-1:0] r_wdata;
  logic [DATA_W-1:0] merged;
  logic              r_vec;

  // Named events for the checker
  logic accept_evt;
  logic drop_evt;
  logic vec_wr;

  ipi_cmd_decode #(.NUM_CORES(NUM_CORES)) u_dec (
    .word  (cmd_word),
    .kind  (cmd_kind),
    .is64  (cmd_is64),
    .req   (dec_req),
    .legal (dec_legal)
  );

  ipi_byte_merge u_merge (
    .old_word (m_rdata),
    .new_word (r_wdata),
    .keep     (r_keep),
    .merged   (merged)
  );

  assign cmd_ready  = (st == ST_IDLE);
  assign accept_evt = cmd_valid && cmd_ready;
  assign drop_evt   = accept_evt && !dec_legal;
  assign m_rd       = (st == ST_READ);
  assign m_wr       = (st == ST_WRITE);
  assign m_wdata    = r_wdata;
  assign vec_wr     = m_wr && r_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      m_core  <= '0;
      m_addr  <= '0;
      r_keep  <= '0;
      r_wdata <= '0;
      r_vec   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept_evt && dec_legal) begin
          m_core  <= dec_req.core;
          m_addr  <= dec_req.addr;
          r_keep  <= dec_req.keep;
          r_wdata <= dec_req.payload;
          r_vec   <= dec_req.is_vec;
          st      <= (dec_req.keep != '0) ? ST_READ : ST_WRITE;
        end
        ST_READ:  st <= ST_WAIT;
        ST_WAIT:  if (m_rvalid) begin
          r_wdata <= merged;
          st      <= ST_WRITE;
        end
        ST_WRITE: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ipi_send_dispatch_chk.sv
module ipi_send_dispatch_chk #(
  parameter int NUM_CORES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [63:0] cmd_word,
  input logic [9:0]  m_core,
  input logic [15:0] m_addr,
  input logic        m_rd,
  input logic        m_wr,
  input logic [31:0] m_wdata,
  input logic        drop_evt,
  input logic        vec_wr
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_rd, m_wr}));

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd || m_wr) |-> !cmd_ready);

  // R8
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !(m_rd || m_wr));

  // R9
  core_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && int'(cmd_word[25:16]) >= NUM_CORES) |=> !(m_rd || m_wr));

  // R6
  read_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_rd |=> !m_wr && !m_rd);

  // R6
  read_target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_rd |=> $stable(m_addr) && $stable(m_core));

  // R2
  vec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_wr |-> ($countones(m_wdata) == 1) && (m_addr == 16'h1008));
endmodule

bind ipi_send_dispatch ipi_send_dispatch_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_word  (cmd_word),
  .m_core    (m_core),
  .m_addr    (m_addr),
  .m_rd      (m_rd),
  .m_wr      (m_wr),
  .m_wdata   (m_wdata),
  .drop_evt  (drop_evt),
  .vec_wr    (vec_wr)
);

// File: tb/ipi_send_dispatch_bench.sv
module ipi_send_dispatch_bench;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [63:0] cmd_word = '0;
  logic [1:0]  cmd_kind = '0;
  logic        cmd_is64 = 1'b0;
  logic [9:0]  m_core;
  logic [15:0] m_addr;
  logic        m_rd, m_wr;
  logic [31:0] m_wdata;
  logic [31:0] m_rdata = '0;
  logic        m_rvalid = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [int];

  always #5 clk = ~clk;

  ipi_send_dispatch #(.NUM_CORES(NC)) u_ipi_send_dispatch (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .cmd_kind(cmd_kind), .cmd_is64(cmd_is64),
    .m_core(m_core), .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_rvalid(m_rvalid)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int mkey(input logic [9:0] c, input logic [15:0] a);
    return int'(c) * 65536 + int'(a);
  endfunction

  function automatic logic [31:0] mem_rd(input int k);
    if (mem.exists(k)) return mem[k];
    return (32'(k) * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  function automatic bit b_legal(input logic [1:0] k, input bit f64, input logic [63:0] w);
    if (w[25:16] >= 10'(NC)) return 1'b0;
    if (k == 2'd3) return 1'b0;
    if (k != 2'd0 && !f64) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [15:0] b_addr(input logic [1:0] k, input logic [63:0] w);
    case (k)
      2'd0:    return 16'h1008;
      2'd1:    return 16'h1020 + {11'd0, w[4:2], 2'b00};
      default: return w[15:0];
    endcase
  endfunction

  function automatic logic [3:0] b_keep(input logic [1:0] k, input logic [63:0] w);
    return (k == 2'd0) ? 4'h0 : w[30:27];
  endfunction

  function automatic logic [31:0] b_data(input logic [1:0] k, input logic [63:0] w, input logic [31:0] old);
    logic [31:0] r;
    if (k == 2'd0) return 32'h1 << w[4:0];
    r = w[63:32];
    for (int b = 0; b < 4; b++)
      if (w[27+b]) r[b*8 +: 8] = old[b*8 +: 8];
    return r;
  endfunction

  task automatic run_cmd(input logic [1:0] k, input bit f64, input logic [63:0] w);
    int reads = 0;
    bit pend = 0;
    int wait_n = 0;
    bit done = 0;
    logic [31:0] oldv = '0;
    logic [15:0] ea;
    logic [3:0]  ekeep;
    ea = b_addr(k, w);
    ekeep = b_keep(k, w);
    @(negedge clk);
    check(cmd_ready === 1'b1, "R10 idle ready", 64'(cmd_ready), 64'd1);
    cmd_valid = 1'b1; cmd_kind = k; cmd_is64 = f64; cmd_word = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!b_legal(k, f64, w)) begin
      for (int c = 0; c < 3; c++) begin
        if (c > 0) @(negedge clk);
        if (w[25:16] >= 10'(NC))
          check(!m_rd && !m_wr && cmd_ready, "R9 drop", {m_rd, m_wr, cmd_ready}, 64'd1);
        else
          check(!m_rd && !m_wr && cmd_ready, "R8 drop", {m_rd, m_wr, cmd_ready}, 64'd1);
      end
      return;
    end
    check(cmd_ready === 1'b0, "R10 busy", 64'(cmd_ready), 64'd0);
    for (int c = 0; c < 20 && !done; c++) begin
      if (c > 0) @(negedge clk);
      m_rvalid = 1'b0;
      if (pend) begin
        if (wait_n == 0) begin
          m_rvalid = 1'b1;
          m_rdata = oldv;
          pend = 0;
        end else wait_n--;
      end
      if (m_rd) begin
        reads++;
        check(m_core == w[25:16], "R1 read core", 64'(m_core), 64'(w[25:16]));
        check(m_addr == ea, "R6 read addr", 64'(m_addr), 64'(ea));
        oldv = mem_rd(mkey(m_core, m_addr));
        pend = 1;
        wait_n = $urandom_range(0, 2);
      end
      if (m_wr) begin
        logic [31:0] ed;
        done = 1;
        ed = b_data(k, w, oldv);
        if (ekeep != 0) check(reads == 1, "R6 one read", 64'(reads), 64'd1);
        else if (k == 2'd0) check(reads == 0, "R2 no read", 64'(reads), 64'd0);
        else check(reads == 0, "R7 no read", 64'(reads), 64'd0);
        check(m_core == w[25:16], "R1 write core", 64'(m_core), 64'(w[25:16]));
        case (k)
          2'd0: check(m_addr == ea, "R2 addr", 64'(m_addr), 64'(ea));
          2'd1: check(m_addr == ea, "R3 addr", 64'(m_addr), 64'(ea));
          default: check(m_addr == ea, "R4 addr", 64'(m_addr), 64'(ea));
        endcase
        if (k == 2'd0) check(m_wdata == ed, "R2 data", 64'(m_wdata), 64'(ed));
        else if (ekeep != 0) check(m_wdata == ed, "R5 data", 64'(m_wdata), 64'(ed));
        else check(m_wdata == ed, "R7 data", 64'(m_wdata), 64'(ed));
        mem[mkey(m_core, m_addr)] = m_wdata;
      end
    end
    m_rvalid = 1'b0;
    check(done, "R10 write seen", 64'(done), 64'd1);
  endtask

  function automatic logic [63:0] mk(input logic [31:0] pay, input logic [3:0] keep,
                                     input logic [9:0] core, input logic [15:0] lo);
    return {pay, 1'b0, keep, 1'b0, core, lo};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cmd_ready === 1'b1 && !m_rd && !m_wr, "R11 reset", {cmd_ready, m_rd, m_wr}, 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready === 1'b1 && !m_rd && !m_wr, "R11 after reset", {cmd_ready, m_rd, m_wr}, 64'b100);
    // directed corners
    run_cmd(2'd0, 1'b0, mk(32'hFFFF_FFFF, 4'hF, 10'd2, 16'h001F)); // R2 vector 31, mask ignored
    run_cmd(2'd0, 1'b1, mk(32'h0, 4'h0, 10'd0, 16'h0000));         // R2 vector 0
    run_cmd(2'd1, 1'b1, mk(32'hA1B2_C3D4, 4'h0, 10'd3, 16'h001C)); // R3 slot 7, R7
    run_cmd(2'd1, 1'b1, mk(32'h1122_3344, 4'hF, 10'd3, 16'h001C)); // R5 full keep
    run_cmd(2'd2, 1'b1, mk(32'hDEAD_BEEF, 4'h5, 10'd1, 16'h1234)); // R4, R5
    run_cmd(2'd2, 1'b1, mk(32'h0BAD_F00D, 4'hA, 10'd1, 16'h1234)); // R5 alternate lanes
    run_cmd(2'd2, 1'b0, mk(32'h5555_5555, 4'h0, 10'd1, 16'h1234)); // R8 narrow
    run_cmd(2'd1, 1'b0, mk(32'h5555_5555, 4'h3, 10'd0, 16'h0004)); // R8 narrow
    run_cmd(2'd3, 1'b1, mk(32'h5555_5555, 4'h0, 10'd0, 16'h0004)); // R8 reserved
    run_cmd(2'd0, 1'b1, mk(32'h0, 4'h0, 10'd4, 16'h0003));         // R9 core = count
    run_cmd(2'd2, 1'b1, mk(32'h1, 4'h1, 10'd1023, 16'h0100));      // R9 top core id
    // random mix
    for (int i = 0; i < 300; i++) begin
      int sel = $urandom_range(0, 9);
      logic [1:0] k = (sel < 3) ? 2'd0 : (sel < 6) ? 2'd1 : (sel < 9) ? 2'd2 : 2'd3;
      bit f64 = ($urandom_range(0, 7) != 0);
      logic [3:0] keep = ($urandom_range(0, 2) == 0) ? 4'h0 : 4'($urandom);
      logic [9:0] core = 10'($urandom_range(0, 5));
      logic [15:0] lo = 16'($urandom) & 16'h103C | 16'h1000;
      run_cmd(k, f64, mk($urandom, keep, core, lo));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule